// File: doc/BRIEF.md
# Programmable-Timing Asynchronous SRAM Controller

This block lets a synchronous host reach one bank of asynchronous static memory. The host offers a byte address, a 16-bit write value and a direction flag under a valid/ready handshake. The controller then plays out the access on the memory pins: active-low chip select, output enable, read strobe and write strobe, a halfword address, and a bidirectional 16-bit data bus. Reads return the captured bus value with a one-cycle valid pulse.

Every access runs through a fixed order of phases, and each phase has its own programmed length: an optional direction-change gap, pre-setup, setup, pre-access, access, hold, and a closing idle gap. A 32-bit timing word holds setup, hold and access counts for writes in its low half and for reads in its high half. A 16-bit extended word holds the pre-setup, pre-access, direction-change and idle counts. A phase with a length of zero is skipped. The timing inputs must stay stable while an access is in flight. The host can only issue requests while the bank enable input is high.

Top module: `async_sram_ctl`

## Requirements
- R1: While `cfg_en` is low, `req_ready` is low, no request is accepted, and chip select stays high.
- R2: Setup length comes from bits 2:0 of the direction's field (timing bits 2:0 for writes, bits 18:16 for reads). A value of 1 to 7 gives that many cycles and 0 gives 8. During setup, chip select is low and both strobes are high.
- R3: Access length comes from timing bits 15:8 for writes and 31:24 for reads. A value of N ≥ 1 holds the direction's strobe low for N cycles, and 0 is treated as 1.
- R4: Hold length comes from timing bits 6:4 for writes and 22:20 for reads. It gives that many cycles of chip select low after the strobe rises, and 0 gives none.
- R5: Pre-setup (extended bits 1:0) gives cycles with chip select high before setup. Pre-access (extended bits 5:4) gives cycles between setup and access with chip select low and strobes high.
- R6: For a read, output enable is low during pre-access and access, and the read strobe is low only during access. The bus is sampled on the last access cycle. `rd_valid` pulses for exactly the next cycle, with the sampled value on `rd_data`.
- R7: For a write, the controller drives the write value on the bus from the first setup cycle through the last hold cycle and releases it otherwise. The write strobe is low only during access.
- R8: When an accepted request has the opposite direction to the previous accepted one, the controller first inserts the direction-change count (extended bits 10:8) of cycles with chip select high. This never happens for the first access after reset.
- R9: After every access, the controller inserts the idle count (extended bits 14:12) of cycles with chip select high and `req_ready` low.
- R10: `req_ready` rises in the cycle after the last phase. With minimum settings each access takes three cycles, and back-to-back accesses each give a separate strobe pulse.
- R11: After reset, all memory controls are high, the bus is released, `rd_valid` is low, and `req_ready` follows `cfg_en`.
- R12: `mem_addr` equals `req_addr` with bit 0 dropped. It is latched at acceptance and held until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Bank enable |
| cfg_timing | input | 32 | Setup/hold/access counts, writes low half, reads high half |
| cfg_ext | input | 16 | Pre-setup, pre-access, direction-change and idle counts |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write value |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | DW | Captured read value |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW-1 | Halfword address |
| mem_dq | inout | DW | Data bus |

## Verification
The assertions check relations that must hold in every cycle. A strobe is never low without chip select. The two strobes are never low together. Output enable is never low during a write. A falling strobe always follows a cycle of chip select low. `rd_valid` is a single-cycle pulse that comes right after a read strobe. `req_ready` is low whenever the bank is disabled. Only the bench scenarios can show the exact length of each phase under each field encoding (including setup zero giving eight and access zero giving one), whether the direction-change gap appears only on a direction switch, and whether written data comes back through later reads.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;

  localparam int ACC_W  = 8;
  localparam int DIR_WR = 0;
  localparam int DIR_RD = 1;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_TURN  = 3'd1,
    PH_PRE   = 3'd2,
    PH_SETUP = 3'd3,
    PH_PACC  = 3'd4,
    PH_ACC   = 3'd5,
    PH_HOLD  = 3'd6,
    PH_GAP   = 3'd7
  } phase_t;

  typedef struct packed {
    logic [3:0]       setup;
    logic [ACC_W-1:0] acc;
    logic [2:0]       hold;
  } dir_len_t;

  typedef struct packed {
    logic [2:0] turn;
    logic [1:0] pre;
    logic [1:0] pacc;
    logic [2:0] gap;
  } ext_len_t;

  function automatic logic [ACC_W-1:0] phase_len(phase_t p, dir_len_t d, ext_len_t e);
    logic [ACC_W-1:0] n;
    case (p)
      PH_TURN:  n = ACC_W'(e.turn);
      PH_PRE:   n = ACC_W'(e.pre);
      PH_SETUP: n = ACC_W'(d.setup);
      PH_PACC:  n = ACC_W'(e.pacc);
      PH_ACC:   n = d.acc;
      PH_HOLD:  n = ACC_W'(d.hold);
      PH_GAP:   n = ACC_W'(e.gap);
      default:  n = '0;
    endcase
    return n;
  endfunction

  // Next phase with a non-zero length; setup and access are never empty.
  function automatic phase_t phase_after(phase_t p, dir_len_t d, ext_len_t e);
    phase_t n;
    case (p)
      PH_IDLE, PH_TURN: n = (e.pre != 2'd0) ? PH_PRE : PH_SETUP;
      PH_PRE:           n = PH_SETUP;
      PH_SETUP:         n = (e.pacc != 2'd0) ? PH_PACC : PH_ACC;
      PH_PACC:          n = PH_ACC;
      PH_ACC:           n = (d.hold != 3'd0) ? PH_HOLD :
                            ((e.gap != 3'd0) ? PH_GAP : PH_IDLE);
      PH_HOLD:          n = (e.gap != 3'd0) ? PH_GAP : PH_IDLE;
      default:          n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/async_sram_timing.sv
module async_sram_timing
  import async_sram_pkg::*;
(
  input  logic [31:0]          cfg_timing,
  input  logic [15:0]          cfg_ext,
  output dir_len_t [1:0]       len_dir,
  output ext_len_t             len_ext
);

  // Index 0 decodes the write half, index 1 the read half.
  for (genvar g = 0; g < 2; g++) begin : g_dir
    logic [15:0] fld;
    assign fld              = cfg_timing[16*g +: 16];
    assign len_dir[g].setup = (fld[2:0] == 3'd0) ? 4'd8 : {1'b0, fld[2:0]};
    assign len_dir[g].acc   = (fld[15:8] == '0) ? ACC_W'(1) : fld[15:8];
    assign len_dir[g].hold  = fld[6:4];
  end

  assign len_ext.pre  = cfg_ext[1:0];
  assign len_ext.pacc = cfg_ext[5:4];
  assign len_ext.turn = cfg_ext[10:8];
  assign len_ext.gap  = cfg_ext[14:12];

endmodule

// File: rtl/async_sram_fsm.sv
module async_sram_fsm
  import async_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             req_valid,
  input  logic             req_we,
  input  dir_len_t [1:0]   len_dir,
  input  ext_len_t         len_ext,
  output logic             req_ready,
  output logic             accept,
  output phase_t           ph_q,
  output phase_t           ph_nxt,
  output logic [ACC_W-1:0] cnt_q,
  output logic             we_q,
  output logic             we_nxt
);

  logic             have_q;
  logic             turn;
  dir_len_t         dl;
  logic [ACC_W-1:0] cnt_nxt;

  assign req_ready = cfg_en && (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign we_nxt    = accept ? req_we : we_q;
  assign dl        = we_nxt ? len_dir[DIR_WR] : len_dir[DIR_RD];
  assign turn      = have_q && (req_we != we_q) && (len_ext.turn != 3'd0);

  always_comb begin
    ph_nxt  = ph_q;
    cnt_nxt = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (accept) begin
        ph_nxt  = turn ? PH_TURN : phase_after(PH_TURN, dl, len_ext);
        cnt_nxt = phase_len(ph_nxt, dl, len_ext) - ACC_W'(1);
      end
    end else if (cnt_q == '0) begin
      ph_nxt  = phase_after(ph_q, dl, len_ext);
      cnt_nxt = (ph_nxt == PH_IDLE) ? '0 : phase_len(ph_nxt, dl, len_ext) - ACC_W'(1);
    end else begin
      cnt_nxt = cnt_q - ACC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      we_q   <= 1'b0;
      have_q <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      cnt_q <= cnt_nxt;
      we_q  <= we_nxt;
      if (accept) have_q <= 1'b1;
    end
  end

endmodule

// File: rtl/async_sram_pins.sv
module async_sram_pins
  import async_sram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  phase_t           ph_q,
  input  logic [ACC_W-1:0] cnt_q,
  input  logic             we_q,
  input  phase_t           ph_nxt,
  input  logic             we_nxt,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic             cs_n,
  output logic             oe_n,
  output logic             rd_n,
  output logic             we_n,
  output logic [AW-2:0]    addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);

  logic cs_on, oe_on, rd_on, wr_on, capture;

  assign cs_on   = ph_nxt inside {PH_SETUP, PH_PACC, PH_ACC, PH_HOLD};
  assign oe_on   = !we_nxt && (ph_nxt inside {PH_PACC, PH_ACC});
  assign rd_on   = !we_nxt && (ph_nxt == PH_ACC);
  assign wr_on   = we_nxt && (ph_nxt == PH_ACC);
  assign capture = (ph_q == PH_ACC) && (cnt_q == '0) && !we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= 1'b1;
      oe_n     <= 1'b1;
      rd_n     <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      addr     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      cs_n     <= !cs_on;
      oe_n     <= !oe_on;
      rd_n     <= !rd_on;
      we_n     <= !wr_on;
      dq_oe    <= we_nxt && cs_on;
      rd_valid <= capture;
      if (accept) begin
        addr   <= req_addr[AW-1:1];
        dq_out <= req_wdata;
      end
      if (capture) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import async_sram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic [31:0]   cfg_timing,
  input  logic [15:0]   cfg_ext,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_rd_n,
  output logic          mem_we_n,
  output logic [AW-2:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq
);

  dir_len_t [1:0]   len_dir;
  ext_len_t         len_ext;
  logic             accept, we_q, we_nxt, dq_oe;
  phase_t           ph_q, ph_nxt;
  logic [ACC_W-1:0] cnt_q;
  logic [DW-1:0]    dq_out;

  async_sram_timing u_timing (
    .cfg_timing (cfg_timing),
    .cfg_ext    (cfg_ext),
    .len_dir    (len_dir),
    .len_ext    (len_ext)
  );

  async_sram_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .req_valid (req_valid),
    .req_we    (req_we),
    .len_dir   (len_dir),
    .len_ext   (len_ext),
    .req_ready (req_ready),
    .accept    (accept),
    .ph_q      (ph_q),
    .ph_nxt    (ph_nxt),
    .cnt_q     (cnt_q),
    .we_q      (we_q),
    .we_nxt    (we_nxt)
  );

  async_sram_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ph_q      (ph_q),
    .cnt_q     (cnt_q),
    .we_q      (we_q),
    .ph_nxt    (ph_nxt),
    .we_nxt    (we_nxt),
    .dq_in     (mem_dq),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .rd_n      (mem_rd_n),
    .we_n      (mem_we_n),
    .addr      (mem_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign mem_dq = dq_oe ? dq_out : {DW{1'bz}};

endmodule

// File: rtl/async_sram_ctl_chk.sv
module async_sram_ctl_chk (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic req_ready,
  input logic rd_valid,
  input logic mem_cs_n,
  input logic mem_oe_n,
  input logic mem_rd_n,
  input logic mem_we_n
);

  assert_no_accept_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> !req_ready);

  assert_setup_before_write_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  assert_setup_before_read_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_rd_n) |-> $past(!mem_cs_n));

  assert_strobe_needs_cs_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n || !mem_we_n) |-> !mem_cs_n);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && !mem_we_n));

  assert_oe_not_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!mem_rd_n));

  assert_ready_bus_idle_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_cs_n);

endmodule

bind async_sram_ctl async_sram_ctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_en    (cfg_en),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_rd_n  (mem_rd_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/async_sram_ctl_tb_top.sv
`timescale 1ns/1ps
module async_sram_ctl_tb_top;

  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic [31:0]   cfg_timing = '0;
  logic [15:0]   cfg_ext = '0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic          mem_cs_n, mem_oe_n, mem_rd_n, mem_we_n;
  logic [AW-2:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  int vectors = 0;
  int miscompares = 0;

  logic [DW-1:0] sram   [0:63];
  logic [DW-1:0] shadow [0:63];
  bit            have_prev = 0;
  bit            last_w = 0;

  always #4 clk = ~clk;

  async_sram_ctl #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_timing(cfg_timing), .cfg_ext(cfg_ext),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  // Asynchronous SRAM model: drives while selected and output-enabled.
  assign mem_dq = (!mem_cs_n && !mem_oe_n) ? sram[mem_addr[5:0]] : {DW{1'bz}};

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) sram[i] <= 16'(i * 16'h0101) ^ 16'h5a5a;
    end else if (!mem_cs_n && !mem_we_n) begin
      sram[mem_addr[5:0]] <= mem_dq;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected per-cycle pins {cs_n, oe_n, rd_n, we_n, ready} and bus-drive flag.
  logic [4:0] q_pins [$];
  bit         q_drv  [$];
  string      q_tag  [$];

  task automatic push(input int n, input logic [4:0] p, input bit drv, input string tag);
    for (int i = 0; i < n; i++) begin
      q_pins.push_back(p);
      q_drv.push_back(drv);
      q_tag.push_back(tag);
    end
  endtask

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [15:0] f;
    int st, ac, hd, pr, pa, tr, gp, vidx;
    f  = w ? cfg_timing[15:0] : cfg_timing[31:16];
    st = (f[2:0] == 3'd0) ? 8 : int'(f[2:0]);
    ac = (f[15:8] == 8'd0) ? 1 : int'(f[15:8]);
    hd = int'(f[6:4]);
    pr = int'(cfg_ext[1:0]);
    pa = int'(cfg_ext[5:4]);
    tr = (have_prev && (w != last_w)) ? int'(cfg_ext[10:8]) : 0;
    gp = int'(cfg_ext[14:12]);
    q_pins.delete(); q_drv.delete(); q_tag.delete();
    push(tr, 5'b11110, 1'b0, "R8 transition");
    push(pr, 5'b11110, 1'b0, "R5 pre-setup");
    push(st, 5'b01110, w,    "R2 setup");
    push(pa, w ? 5'b01110 : 5'b00110, w, "R5 pre-access");
    push(ac, w ? 5'b01100 : 5'b00010, w, "R3 access");
    vidx = q_pins.size();
    push(hd, 5'b01110, w,    "R4 hold");
    push(gp, 5'b11110, 1'b0, "R9 idle gap");
    push(1,  5'b11111, 1'b0, "R10 ready return");

    vectors++;
    check("R10 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < q_pins.size(); k++) begin
      vectors++;
      check(q_tag[k], 32'({mem_cs_n, mem_oe_n, mem_rd_n, mem_we_n, req_ready}), 32'(q_pins[k]));
      check("R12 halfword address", 32'(mem_addr), 32'(a[AW-1:1]));
      check("R6 rd_valid timing", 32'(rd_valid), 32'(!w && k == vidx));
      if (q_drv[k]) check("R7 write data on bus", 32'(mem_dq), 32'(d));
      if (!w && k == vidx) check("R6 read data", 32'(rd_data), 32'(shadow[a[6:1]]));
      if (k < q_pins.size() - 1) @(negedge clk);
    end
    if (w) shadow[a[6:1]] = d;
    have_prev = 1'b1;
    last_w    = w;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 16'(i * 16'h0101) ^ 16'h5a5a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    vectors++;
    check("R11 reset pins", 32'({mem_cs_n, mem_oe_n, mem_rd_n, mem_we_n}), 32'hf);
    check("R11 reset ready/valid", 32'({req_ready, rd_valid}), 32'h0);
    // R1 requests ignored while disabled
    req_valid = 1'b1; req_we = 1'b1; req_addr = 12'h010; req_wdata = 16'hdead;
    for (int i = 0; i < 5; i++) begin
      vectors++;
      check("R1 ready low while disabled", 32'(req_ready), 32'd0);
      check("R1 chip select idle while disabled", 32'(mem_cs_n), 32'd1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    cfg_en = 1'b1;
    @(negedge clk);
    vectors++;
    check("R1 no write happened while disabled", 32'(mem_cs_n), 32'd1);

    // Minimum timing: setup 1, access 1, hold 0, no extended gaps (R10)
    cfg_timing = 32'h0101_0101;
    cfg_ext    = 16'h0000;
    access(1'b1, 12'h002, 16'h1111);
    access(1'b1, 12'h004, 16'h2222);
    access(1'b1, 12'h006, 16'h3333);
    access(1'b0, 12'h002, 16'h0);
    access(1'b0, 12'h004, 16'h0);
    access(1'b0, 12'h006, 16'h0);
    access(1'b0, 12'h010, 16'h0);  // R1: confirms the disabled request left no trace

    // Write: setup 0 -> 8, access 0 -> 1, hold 3. Read: setup 3, access 5, hold 2.
    cfg_timing = 32'h0523_0030;
    cfg_ext    = 16'h4532;
    access(1'b1, 12'h020, 16'habcd);
    access(1'b1, 12'h022, 16'h1234);
    access(1'b0, 12'h020, 16'h0);
    access(1'b0, 12'h022, 16'h0);
    access(1'b1, 12'h024, 16'h0f0f);
    access(1'b0, 12'h024, 16'h0);

    // Write: setup 7, access 2, hold 7. Read: setup 0 -> 8, access 0 -> 1, hold 0.
    cfg_timing = 32'h0000_0277;
    cfg_ext    = 16'h0713;
    access(1'b1, 12'h07e, 16'hc3c3);
    access(1'b0, 12'h07e, 16'h0);
    access(1'b1, 12'h040, 16'h7777);
    access(1'b0, 12'h040, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule